// File: doc/BRIEF.md
# Peripheral DMA Channel Engine

This block is a single channel of a small peripheral DMA controller. Software programs four 32-bit registers through an APB-style slave port: a source address, a destination address, a 24-bit transfer-cycle count and a control/status word. Setting the enable bit starts the transfer. The channel reads one element from the source address over a single-beat master port, writes it to the destination address, and moves each address by its own signed step. It repeats this until the cycle count reaches zero.

In burst mode each cycle is four read/write beat pairs instead of one, so the address movement per cycle is four times the coded step. A cycle can be made to wait for one of fifteen peripheral request lines. When the cycle completes, the matching grant line pulses. A finished transfer or a failed bus access stops the channel and raises a maskable interrupt. Software clears either status flag by writing zero to it.

Top module: `pdma_channel`

## Requirements
- R1: After reset all four registers read as zero, and `irq`, `m_req` and `grant` are low.
- R2: The register at `paddr` 0x0 holds the source address, 0x4 the destination address and 0x8 the cycle count. The cycle count keeps only bits 23:0. The control word at 0xC reads back only its defined bits (mask 0x0F3F77EC plus status bits 1 and 4). A write cannot set a status bit.
- R3: Each beat issues a read (`m_we`=0) at the source address and then a write (`m_we`=1) at the destination address, carrying the data that was read. `m_mem` comes from control bit 6 on reads and bit 7 on writes, and `m_size` comes from control bits 21:20. A request holds its address until `m_ack`.
- R4: The step codes are in bits 10:8 (source) and 14:12 (destination). Each completed beat moves an address by 0, +1, +2, +4, 0, −1, −2 or −4 for codes 0 to 7.
- R5: With burst (bit 3) set, one cycle is four beats. The cycle count falls by one per cycle, so a burst cycle moves each address by four times its step.
- R6: Reading 0x8 while a transfer is in progress returns the number of cycles still to run.
- R7: When the last cycle completes, finish status (bit 1) is set, enable (bit 0) clears and no further bus access is made. `irq` is high while finish status and finish-interrupt enable (bit 2) are both set.
- R8: Enabling with a cycle count of zero sets finish status in the same write and clears enable, with no bus access.
- R9: An access acknowledged with `m_err` sets error status (bit 4), clears enable and ends the transfer. `irq` follows error status AND error-interrupt enable (bit 5).
- R10: Writing 0 to a status bit clears it. Writing 1 to it leaves it unchanged.
- R11: A nonzero line number in bits 27:24 (source) or 19:16 (destination) selects request line n (`dreq[n-1]`). Each cycle waits until that line is high. `grant[n-1]` pulses for exactly one clock after the cycle completes.
- R12: While the channel is busy, writes to the address and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write strobe |
| paddr | input | 4 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| m_req | output | 1 | Master access request, held until acknowledged |
| m_we | output | 1 | Access is a write |
| m_addr | output | ADDR_W | Access address |
| m_wdata | output | 32 | Write data |
| m_size | output | 2 | Element width: 0 word, 1 half, 2 byte |
| m_mem | output | 1 | Bus side: 0 peripheral, 1 memory |
| m_ack | input | 1 | Access complete |
| m_err | input | 1 | Access failed (valid with m_ack) |
| m_rdata | input | 32 | Read data (valid with m_ack) |
| dreq | input | 15 | Peripheral request lines 1 to 15 |
| grant | output | 15 | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is a transfer that is paused between cycles with part of its count still left. Only in that state can the live remaining count be read, and only there can the ignored writes to the address and count registers be tried. The stimulus reaches it by holding the selected request line high only until the first destination write is seen on the master port. The line is then dropped, so the channel parks in its wait state after exactly one cycle. There the bench reads the count, attempts the ignored writes, and checks the single grant pulse before raising the request line again. Error handling is reached by having the bench's bus model fail a chosen access.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int LINE_W    = 4;
    localparam int NUM_LINES = (1 << LINE_W) - 1;

    // bits software may write directly (status bits handled separately)
    localparam logic [31:0] CTRL_WMASK = 32'h0F3F_77EC;

    localparam logic [1:0] OFS_SRC = 2'd0;
    localparam logic [1:0] OFS_DST = 2'd1;
    localparam logic [1:0] OFS_CNT = 2'd2;
    localparam logic [1:0] OFS_CTL = 2'd3;

    typedef struct packed {
        logic [3:0]        rsv_hi;
        logic [LINE_W-1:0] src_line;
        logic [1:0]        rsv_w;
        logic [1:0]        width;
        logic [LINE_W-1:0] dst_line;
        logic              rsv_d;
        logic [2:0]        dst_step;
        logic              rsv_s;
        logic [2:0]        src_step;
        logic              dst_mem;
        logic              src_mem;
        logic              err_ie;
        logic              err_st;
        logic              burst;
        logic              fin_ie;
        logic              fin_st;
        logic              en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE
    } eng_state_t;

    function automatic logic signed [3:0] step_amt(input logic [2:0] code);
        case (code)
            3'b001:  return 4'sd1;
            3'b010:  return 4'sd2;
            3'b011:  return 4'sd4;
            3'b101:  return -4'sd1;
            3'b110:  return -4'sd2;
            3'b111:  return -4'sd4;
            default: return 4'sd0;
        endcase
    endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              beat_done,
    input  logic              cyc_done,
    input  logic              bus_err,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl
);

    logic [ADDR_W-1:0] src_n, dst_n;
    logic [CNT_W-1:0]  cnt_n;
    ctrl_t             ctrl_n, ctrl_w;

    function automatic logic [ADDR_W-1:0] sext(input logic signed [3:0] a);
        return {{(ADDR_W-4){a[3]}}, a};
    endfunction

    always_comb begin
        src_n  = src_addr;
        dst_n  = dst_addr;
        cnt_n  = cnt;
        ctrl_n = ctrl;
        ctrl_w = ctrl_t'(wdata & CTRL_WMASK);

        if (wr_en) begin
            case (idx)
                OFS_SRC: if (!busy) src_n = wdata[ADDR_W-1:0];
                OFS_DST: if (!busy) dst_n = wdata[ADDR_W-1:0];
                OFS_CNT: if (!busy) cnt_n = wdata[CNT_W-1:0];
                default: begin
                    if (busy) begin
                        // only stop and interrupt enables change mid-run
                        ctrl_n.en     = ctrl.en & wdata[0];
                        ctrl_n.fin_ie = wdata[2];
                        ctrl_n.err_ie = wdata[5];
                    end else begin
                        ctrl_n    = ctrl_w;
                        ctrl_n.en = wdata[0];
                        if (wdata[0] && cnt == '0) begin
                            ctrl_n.en     = 1'b0;
                            ctrl_n.fin_st = 1'b1;
                        end
                    end
                    if (!(wdata[0] && !busy && cnt == '0))
                        ctrl_n.fin_st = ctrl.fin_st & wdata[1];
                    ctrl_n.err_st = ctrl.err_st & wdata[4];
                end
            endcase
        end

        // engine events take priority over software writes
        if (beat_done) begin
            src_n = src_addr + sext(step_amt(ctrl.src_step));
            dst_n = dst_addr + sext(step_amt(ctrl.dst_step));
        end
        if (cyc_done) begin
            cnt_n = cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                ctrl_n.fin_st = 1'b1;
                ctrl_n.en     = 1'b0;
            end
        end
        if (bus_err) begin
            ctrl_n.err_st = 1'b1;
            ctrl_n.en     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr <= '0;
            dst_addr <= '0;
            cnt      <= '0;
            ctrl     <= '0;
        end else begin
            src_addr <= src_n;
            dst_addr <= dst_n;
            cnt      <= cnt_n;
            ctrl     <= ctrl_n;
        end
    end

    always_comb begin
        case (idx)
            OFS_SRC: rdata = 32'(src_addr);
            OFS_DST: rdata = 32'(dst_addr);
            OFS_CNT: rdata = 32'(cnt);
            default: rdata = ctrl;
        endcase
    end

endmodule

// File: rtl/pdma_handshake.sv
module pdma_handshake
    import pdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LINE_W-1:0]    src_line,
    input  logic [LINE_W-1:0]    dst_line,
    input  logic [NUM_LINES-1:0] dreq,
    input  logic                 cyc_done,
    output logic                 ready,
    output logic [NUM_LINES-1:0] grant
);

    logic [NUM_LINES-1:0] sel;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign sel[g] = (src_line == LINE_W'(g + 1)) ||
                            (dst_line == LINE_W'(g + 1));
        end
    endgenerate

    // every selected line must be requesting; no selection means free-running
    assign ready = &(dreq | ~sel);

    always_ff @(posedge clk) begin
        if (rst)
            grant <= '0;
        else
            grant <= cyc_done ? sel : '0;
    end

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BEATS = 4,
    localparam int BEAT_W     = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              burst,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              src_mem,
    input  logic              dst_mem,
    input  logic [1:0]        width,
    input  logic              ready,
    input  logic              m_ack,
    input  logic              m_err,
    input  logic [31:0]       m_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    output logic [1:0]        m_size,
    output logic              m_mem,
    output logic              beat_done,
    output logic              cyc_done,
    output logic              bus_err,
    output logic              idle
);

    eng_state_t        state_q, state_n;
    logic [BEAT_W-1:0] beat_q, beat_n;
    logic [31:0]       data_q;
    logic              ack, last_beat;

    assign m_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign m_we    = (state_q == ST_WRITE);
    assign m_addr  = m_we ? dst_addr : src_addr;
    assign m_mem   = m_we ? dst_mem : src_mem;
    assign m_size  = width;
    assign m_wdata = data_q;
    assign idle    = (state_q == ST_IDLE);

    assign ack       = m_req && m_ack;
    assign bus_err   = ack && m_err;
    assign beat_done = (state_q == ST_WRITE) && ack && !m_err;
    assign last_beat = !burst || (beat_q == BEAT_W'(BURST_BEATS - 1));
    assign cyc_done  = beat_done && last_beat;

    always_comb begin
        state_n = state_q;
        beat_n  = beat_q;
        case (state_q)
            ST_IDLE: begin
                beat_n = '0;
                if (en) state_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (!en)        state_n = ST_IDLE;
                else if (ready) state_n = ST_READ;
            end
            ST_READ: begin
                if (ack) state_n = (m_err || !en) ? ST_IDLE : ST_WRITE;
            end
            default: begin
                if (ack) begin
                    if (m_err || !en) begin
                        state_n = ST_IDLE;
                    end else if (last_beat) begin
                        state_n = ST_WAIT;
                        beat_n  = '0;
                    end else begin
                        state_n = ST_READ;
                        beat_n  = beat_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            beat_q  <= beat_n;
            if (state_q == ST_READ && ack && !m_err)
                data_q <= m_rdata;
        end
    end

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [3:0]           paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    output logic                 m_req,
    output logic                 m_we,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [31:0]          m_wdata,
    output logic [1:0]           m_size,
    output logic                 m_mem,
    input  logic                 m_ack,
    input  logic                 m_err,
    input  logic [31:0]          m_rdata,
    input  logic [NUM_LINES-1:0] dreq,
    output logic [NUM_LINES-1:0] grant,
    output logic                 irq
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  cnt;
    logic              beat_done, cyc_done, bus_err, idle, ready, busy, wr_en;
    logic              ctl_en, ctl_fin;
    logic              unused_paddr;

    assign unused_paddr = ^paddr[1:0];
    assign wr_en   = psel && penable && pwrite;
    assign busy    = ctrl.en || !idle;
    assign ctl_en  = ctrl.en;
    assign ctl_fin = ctrl.fin_st;
    assign irq     = (ctrl.fin_st && ctrl.fin_ie) || (ctrl.err_st && ctrl.err_ie);

    pdma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .idx       (paddr[3:2]),
        .wdata     (pwdata),
        .rdata     (prdata),
        .busy      (busy),
        .beat_done (beat_done),
        .cyc_done  (cyc_done),
        .bus_err   (bus_err),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .cnt       (cnt),
        .ctrl      (ctrl)
    );

    pdma_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .src_line (ctrl.src_line),
        .dst_line (ctrl.dst_line),
        .dreq     (dreq),
        .cyc_done (cyc_done),
        .ready    (ready),
        .grant    (grant)
    );

    pdma_engine #(
        .ADDR_W      (ADDR_W),
        .BURST_BEATS (BURST_BEATS)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .burst     (ctrl.burst),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .src_mem   (ctrl.src_mem),
        .dst_mem   (ctrl.dst_mem),
        .width     (ctrl.width),
        .ready     (ready),
        .m_ack     (m_ack),
        .m_err     (m_err),
        .m_rdata   (m_rdata),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_size    (m_size),
        .m_mem     (m_mem),
        .beat_done (beat_done),
        .cyc_done  (cyc_done),
        .bus_err   (bus_err),
        .idle      (idle)
    );

endmodule

// File: rtl/pdma_channel_sva.sv
module pdma_channel_sva
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 m_req,
    input logic                 m_we,
    input logic                 m_ack,
    input logic                 m_err,
    input logic [ADDR_W-1:0]    m_addr,
    input logic [NUM_LINES-1:0] grant,
    input logic                 ctl_en,
    input logic                 ctl_fin,
    input logic [CNT_W-1:0]     cnt
);

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we)); // R3

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (grant == '0)); // R11

    AST_FIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_fin) |-> !m_req); // R7

    AST_ERR_STOP: assert property (@(posedge clk) disable iff (rst)
        m_req && m_ack && m_err |=> !ctl_en); // R9

    AST_NO_ACCESS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !m_req); // R8

    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        ctl_en && $past(ctl_en) |-> cnt <= $past(cnt)); // R12

endmodule

bind pdma_channel pdma_channel_sva #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk     (clk),
    .rst     (rst),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .m_addr  (m_addr),
    .grant   (grant),
    .ctl_en  (ctl_en),
    .ctl_fin (ctl_fin),
    .cnt     (cnt)
);

// File: tb/pdma_channel_bench.sv
module pdma_channel_bench;
    import pdma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int LOG_N      = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]           paddr = '0;
    logic [31:0]          pwdata = '0;
    logic [31:0]          prdata;
    logic                 m_req, m_we, m_mem;
    logic [ADDR_W-1:0]    m_addr;
    logic [31:0]          m_wdata;
    logic [1:0]           m_size;
    logic                 m_ack, m_err;
    logic [31:0]          m_rdata;
    logic [NUM_LINES-1:0] dreq = '0;
    logic [NUM_LINES-1:0] grant;
    logic                 irq;

    int n_chk = 0;
    int n_err = 0;
    int acc_n;
    int err_at = -1;
    int g_hi = 0;
    int g_other = 0;

    logic [31:0] la_addr [LOG_N];
    logic [31:0] la_wd   [LOG_N];
    logic        la_we   [LOG_N];
    logic        la_mem  [LOG_N];
    logic [1:0]  la_sz   [LOG_N];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdma_channel u_pdma_channel (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_size(m_size), .m_mem(m_mem), .m_ack(m_ack), .m_err(m_err),
        .m_rdata(m_rdata), .dreq(dreq), .grant(grant), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    // bus model: acknowledge one cycle after request, log every access
    always @(posedge clk) begin
        if (rst) begin
            m_ack   <= 1'b0;
            m_err   <= 1'b0;
            m_rdata <= '0;
            acc_n   <= 0;
        end else if (m_req && !m_ack) begin
            m_ack   <= 1'b1;
            m_err   <= (acc_n == err_at);
            m_rdata <= pat(m_addr);
            if (acc_n < LOG_N) begin
                la_addr[acc_n] <= m_addr;
                la_wd[acc_n]   <= m_wdata;
                la_we[acc_n]   <= m_we;
                la_mem[acc_n]  <= m_mem;
                la_sz[acc_n]   <= m_size;
            end
            acc_n <= acc_n + 1;
        end else begin
            m_ack <= 1'b0;
            m_err <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (grant[2]) g_hi++;
            if (|(grant & ~15'h0004)) g_other++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            apb_read(4'hC, v);
            if (!v[0]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_acc(input string tag, input int k, input logic [31:0] a,
                           input logic we, input logic mem, input logic [1:0] sz);
        chk({tag, " addr"}, la_addr[k], a);
        chk({tag, " dir"},  32'(la_we[k]), 32'(we));
        chk({tag, " bus"},  32'(la_mem[k]), 32'(mem));
        chk({tag, " size"}, 32'(la_sz[k]), 32'(sz));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            apb_read(4'(i * 4), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk("R1 m_req", 32'(m_req), 0);
        chk("R1 grant", 32'(grant), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        apb_write(4'h0, 32'hDEAD_BEE0);
        apb_write(4'h4, 32'h1234_5678);
        apb_write(4'h8, 32'hFF12_3456);
        apb_write(4'hC, 32'hFFFF_FFFE);
        apb_read(4'h0, v); chk("R2 src", v, 32'hDEAD_BEE0);
        apb_read(4'h4, v); chk("R2 dst", v, 32'h1234_5678);
        apb_read(4'h8, v); chk("R2 count 24 bit", v, 32'h0012_3456);
        apb_read(4'hC, v); chk("R2 ctrl mask", v, 32'h0F3F_77EC);
        apb_write(4'hC, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int b = acc_n;
        apb_write(4'h0, 32'h1000);
        apb_write(4'h4, 32'h2000);
        apb_write(4'h8, 32'd3);
        apb_write(4'hC, 32'h0020_7185);
        wait_idle();
        chk("R3 access count", 32'(acc_n - b), 32'd6);
        for (int k = 0; k < 3; k++) begin
            chk_acc("R4 read", b + 2*k, 32'h1000 + 32'(k), 1'b0, 1'b0, 2'd2);
            chk_acc("R4 write", b + 2*k + 1, 32'h2000 - 32'(4*k), 1'b1, 1'b1, 2'd2);
            chk("R3 data", la_wd[b + 2*k + 1], pat(32'h1000 + 32'(k)));
        end
        apb_read(4'h0, v); chk("R4 src end", v, 32'h1003);
        apb_read(4'h4, v); chk("R4 dst end", v, 32'h1FF4);
        apb_read(4'h8, v); chk("R7 count zero", v, 32'h0);
        apb_read(4'hC, v); chk("R7 ctrl done", v, 32'h0020_7186);
        chk("R7 irq", 32'(irq), 1);
    endtask

    task automatic t_status();
        logic [31:0] v;
        apb_write(4'hC, 32'h6);
        apb_read(4'hC, v); chk("R10 write 1 keeps", v, 32'h6);
        chk("R10 irq kept", 32'(irq), 1);
        apb_write(4'hC, 32'h4);
        apb_read(4'hC, v); chk("R10 write 0 clears", v, 32'h4);
        chk("R10 irq cleared", 32'(irq), 0);
        apb_write(4'hC, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        int b = acc_n;
        apb_write(4'h0, 32'h3000);
        apb_write(4'h4, 32'h4000);
        apb_write(4'h8, 32'd2);
        apb_write(4'hC, 32'h0000_4349);
        wait_idle();
        chk("R5 access count", 32'(acc_n - b), 32'd16);
        for (int k = 0; k < 8; k++) begin
            chk_acc("R5 read", b + 2*k, 32'h3000 + 32'(4*k), 1'b0, 1'b1, 2'd0);
            chk_acc("R4 code4 write", b + 2*k + 1, 32'h4000, 1'b1, 1'b0, 2'd0);
        end
        apb_read(4'h0, v); chk("R5 src end", v, 32'h3020);
        apb_read(4'h8, v); chk("R5 count zero", v, 32'h0);
        apb_read(4'hC, v); chk("R5 ctrl done", v, 32'h0000_434A);
        chk("R7 irq masked", 32'(irq), 0);
        apb_write(4'hC, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int b = acc_n;
        apb_write(4'h8, 32'h0);
        apb_write(4'hC, 32'h5);
        apb_read(4'hC, v); chk("R8 instant finish", v, 32'h6);
        repeat (10) @(negedge clk);
        chk("R8 no access", 32'(acc_n - b), 0);
        chk("R8 irq", 32'(irq), 1);
        apb_write(4'hC, 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int b = acc_n;
        err_at = b + 1;
        apb_write(4'h0, 32'h7000);
        apb_write(4'h4, 32'h8000);
        apb_write(4'h8, 32'd5);
        apb_write(4'hC, 32'h0000_1121);
        wait_idle();
        err_at = -1;
        chk("R9 stops after error", 32'(acc_n - b), 32'd2);
        apb_read(4'hC, v); chk("R9 ctrl", v, 32'h0000_1130);
        apb_read(4'h8, v); chk("R9 count kept", v, 32'd5);
        apb_read(4'h0, v); chk("R9 src kept", v, 32'h7000);
        chk("R9 irq", 32'(irq), 1);
        apb_write(4'hC, 32'h20);
        apb_read(4'hC, v); chk("R10 err cleared", v, 32'h20);
        chk("R10 irq low", 32'(irq), 0);
        apb_write(4'hC, 32'h0);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        int b = acc_n;
        int g0 = g_hi;
        apb_write(4'h0, 32'h5000);
        apb_write(4'h4, 32'h6000);
        apb_write(4'h8, 32'd2);
        apb_write(4'hC, 32'h0310_2001);
        repeat (10) @(negedge clk);
        chk("R11 waits for request", 32'(acc_n - b), 0);
        dreq[2] = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (m_req && m_we) break;
        end
        dreq[2] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 one cycle ran", 32'(acc_n - b), 32'd2);
        chk("R11 one grant pulse", 32'(g_hi - g0), 32'd1);
        apb_read(4'h8, v); chk("R6 remaining", v, 32'd1);
        apb_write(4'h0, 32'h9999);
        apb_write(4'h8, 32'd77);
        apb_read(4'h0, v); chk("R12 src write ignored", v, 32'h5000);
        apb_read(4'h8, v); chk("R12 count write ignored", v, 32'd1);
        dreq[2] = 1'b1;
        wait_idle();
        dreq[2] = 1'b0;
        chk("R11 all beats", 32'(acc_n - b), 32'd4);
        chk("R11 grant pulses", 32'(g_hi - g0), 32'd2);
        chk("R11 other grants", 32'(g_other), 0);
        chk_acc("R3 half write", b + 3, 32'h6002, 1'b1, 1'b0, 2'd1);
        apb_read(4'h4, v); chk("R4 dst step 2", v, 32'h6004);
        apb_write(4'hC, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_basic();
        t_status();
        t_burst();
        t_zero();
        t_error();
        t_handshake();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule